// File: doc/BRIEF.md
# Microprogram Sequencer with Opcode Dispatch

This block is the sequencing core of a microprogrammed control unit. A control address register selects one word of a small built-in control store. That word is copied into a control buffer register, and the buffered word then drives the control-signal bus and supplies the next-address information. Each microinstruction takes two clock cycles. In the fetch cycle the word is loaded. In the execute cycle the control signals are driven and the next microaddress is chosen.

Every microword has one of two formats, marked by its top bit. A control-format word carries one bit for each control line, and its successor is the next sequential address. A branch-format word carries a two-bit condition code and a target address, and it drives no control lines. Branch logic picks among three sources for the next address: the incremented address, the target field, or a routine address mapped from the machine opcode. It makes this choice from the condition code and from the zero and negative ALU flags. The opcode is used only at the single dispatch point of each machine-instruction cycle.

Top module: `useq_core`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `uaddr_o` is 0, `exec_o` is 0 and `ctrl_o` is 0. The fetch microroutine starts at address 0.
- R2: Fetch and execute cycles alternate, starting with fetch. `exec_o` is 1 only in execute cycles. `ctrl_o` is all zero in fetch cycles. `uaddr_o` does not change across a fetch edge.
- R3: For a control-format word (bit 12 = 0), the execute cycle drives `ctrl_o` with word bits 11:0. The next microaddress is the current one plus 1, modulo 64.
- R4: For a branch-format word (bit 12 = 1), `ctrl_o` is all zero during its execute cycle.
- R5: Condition code 00 (bits 7:6) jumps to the target in bits 5:0, whatever the flags are.
- R6: Condition code 01 jumps to the target if `flag_z_i` is 1 in the execute cycle. Otherwise it goes to the current address plus 1.
- R7: Condition code 10 jumps to the target if `flag_n_i` is 1 in the execute cycle. Otherwise it goes to the current address plus 1.
- R8: Condition code 11 dispatches to 32 + 4 × `opcode_i`, sampled in the execute cycle. The target field is ignored.
- R9: Flags have no effect in control-format cycles or in unconditional cycles. `flag_n_i` has no effect under code 01, and `flag_z_i` has no effect under code 10.
- R10: `opcode_i` and the flags have no effect in fetch cycles. `opcode_i` has no effect outside dispatch execute cycles.
- R11: Contents of the control store:
  - Address 0: control word 0x001.
  - Address 1: control word 0x002.
  - Address 2: dispatch.
  - Address 8: control word 0x0A0. Address 9: jump to 0.
  - Address 12: control word 0x0C0. Address 13: jump to 0.
  - Routine for opcode k, at base 32 + 4k:
    - Base: control word 0x400 | k<<4.
    - Base+1: for even k, jump to 8 if zero; for odd k, jump to 12 if negative.
    - Base+2: control word 0x200 | k<<4.
    - Base+3: jump to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| opcode_i | input | 3 | Machine-instruction opcode used at dispatch |
| flag_z_i | input | 1 | ALU zero flag |
| flag_n_i | input | 1 | ALU negative flag |
| ctrl_o | output | 12 | Control-signal bus |
| uaddr_o | output | 6 | Current microaddress |
| exec_o | output | 1 | High in execute cycles |

## Verification
The word at a new microaddress appears on `ctrl_o` one cycle after that address shows on `uaddr_o`. A next-address choice made from the inputs seen in an execute cycle appears on `uaddr_o` in the cycle after that. The bench therefore drives inputs and samples outputs on falling edges, and it checks each microinstruction as a pair: one fetch sample and one execute sample. In every fetch cycle and every control-format cycle it drives deliberately wrong opcode and flag values, so that any leak of those inputs shows up as a wrong address in the next fetch sample.

// File: rtl/useq_pkg.sv
package useq_pkg;

    typedef enum logic [1:0] {
        COND_JMP = 2'b00,
        COND_JZ  = 2'b01,
        COND_JN  = 2'b10,
        COND_MAP = 2'b11
    } cond_e;

    typedef enum logic {
        PH_FETCH = 1'b0,
        PH_EXEC  = 1'b1
    } phase_e;

    typedef enum logic [1:0] {
        SRC_INC   = 2'd0,
        SRC_FIELD = 2'd1,
        SRC_MAP   = 2'd2
    } src_e;

endpackage

// File: rtl/useq_rom.sv
module useq_rom #(
    parameter int ADDR_W     = 6,
    parameter int CTRL_W     = 12,
    parameter int OPC_W      = 3,
    parameter int MAP_BASE   = 32,
    parameter int MAP_STRIDE = 4,
    parameter int ZERO_TGT   = 8,
    parameter int NEG_TGT    = 12,
    localparam int WORD_W    = CTRL_W + 1,
    localparam int DEPTH     = 2 ** ADDR_W
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [WORD_W-1:0] word_o
);
    import useq_pkg::*;

    localparam int NOPC = 2 ** OPC_W;

    function automatic logic [WORD_W-1:0] ctrl_word(input int value);
        logic [WORD_W-1:0] w;
        w = '0;
        w[CTRL_W-1:0] = CTRL_W'(value);
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] br_word(input cond_e c, input int tgt);
        logic [WORD_W-1:0] w;
        w = '0;
        w[WORD_W-1]          = 1'b1;
        w[ADDR_W+1:ADDR_W]   = c;
        w[ADDR_W-1:0]        = ADDR_W'(tgt);
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] entry(input int a);
        int k;
        int j;
        if (a == 0)             return ctrl_word(32'h001);
        if (a == 1)             return ctrl_word(32'h002);
        if (a == 2)             return br_word(COND_MAP, 0);
        if (a == ZERO_TGT)      return ctrl_word(32'h0A0);
        if (a == ZERO_TGT + 1)  return br_word(COND_JMP, 0);
        if (a == NEG_TGT)       return ctrl_word(32'h0C0);
        if (a == NEG_TGT + 1)   return br_word(COND_JMP, 0);
        if (a >= MAP_BASE && a < MAP_BASE + NOPC * MAP_STRIDE) begin
            k = (a - MAP_BASE) / MAP_STRIDE;
            j = (a - MAP_BASE) % MAP_STRIDE;
            case (j)
                0: return ctrl_word(32'h400 | (k << 4));
                1: return (k % 2 == 1) ? br_word(COND_JN, NEG_TGT)
                                       : br_word(COND_JZ, ZERO_TGT);
                2: return ctrl_word(32'h200 | (k << 4));
                3: return br_word(COND_JMP, 0);
                default: return ctrl_word(a);
            endcase
        end
        return ctrl_word(a);
    endfunction

    logic [WORD_W-1:0] store [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        assign store[i] = entry(i);
    end

    assign word_o = store[addr_i];

endmodule

// File: rtl/useq_map.sv
module useq_map #(
    parameter int ADDR_W     = 6,
    parameter int OPC_W      = 3,
    parameter int MAP_BASE   = 32,
    parameter int MAP_STRIDE = 4
) (
    input  logic [OPC_W-1:0]  opcode_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam logic [ADDR_W-1:0] BASE_A   = ADDR_W'(MAP_BASE);
    localparam logic [ADDR_W-1:0] STRIDE_A = ADDR_W'(MAP_STRIDE);

    always_comb begin
        addr_o = BASE_A + ADDR_W'(opcode_i) * STRIDE_A;
    end

endmodule

// File: rtl/useq_branch.sv
module useq_branch #(
    parameter int ADDR_W = 6
) (
    input  logic               is_br_i,
    input  useq_pkg::cond_e    cond_i,
    input  logic [ADDR_W-1:0]  target_i,
    input  logic [ADDR_W-1:0]  car_i,
    input  logic               flag_z_i,
    input  logic               flag_n_i,
    input  logic [ADDR_W-1:0]  map_addr_i,
    output logic [ADDR_W-1:0]  next_o
);
    import useq_pkg::*;

    src_e src;

    always_comb begin
        src = SRC_INC;
        if (is_br_i) begin
            case (cond_i)
                COND_JMP: src = SRC_FIELD;
                COND_JZ:  src = flag_z_i ? SRC_FIELD : SRC_INC;
                COND_JN:  src = flag_n_i ? SRC_FIELD : SRC_INC;
                COND_MAP: src = SRC_MAP;
                default:  src = SRC_INC;
            endcase
        end
    end

    always_comb begin
        case (src)
            SRC_FIELD: next_o = target_i;
            SRC_MAP:   next_o = map_addr_i;
            default:   next_o = car_i + ADDR_W'(1);
        endcase
    end

endmodule

// File: rtl/useq_core.sv
module useq_core #(
    parameter int ADDR_W     = 6,
    parameter int CTRL_W     = 12,
    parameter int OPC_W      = 3,
    parameter int MAP_BASE   = 32,
    parameter int MAP_STRIDE = 4,
    parameter int ZERO_TGT   = 8,
    parameter int NEG_TGT    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OPC_W-1:0]  opcode_i,
    input  logic              flag_z_i,
    input  logic              flag_n_i,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [ADDR_W-1:0] uaddr_o,
    output logic              exec_o
);
    import useq_pkg::*;

    localparam int WORD_W = CTRL_W + 1;

    typedef struct packed {
        logic [ADDR_W-1:0] car;
        logic [WORD_W-1:0] cbr;
        phase_e            ph;
    } state_t;

    state_t st_d, st_q;

    logic [WORD_W-1:0] rom_word;
    logic [ADDR_W-1:0] map_addr;
    logic [ADDR_W-1:0] next_addr;

    logic              cbr_is_br;
    cond_e             cbr_cond;
    logic [ADDR_W-1:0] cbr_target;

    assign cbr_is_br  = st_q.cbr[WORD_W-1];
    assign cbr_cond   = cond_e'(st_q.cbr[ADDR_W+1:ADDR_W]);
    assign cbr_target = st_q.cbr[ADDR_W-1:0];

    useq_rom #(
        .ADDR_W(ADDR_W), .CTRL_W(CTRL_W), .OPC_W(OPC_W),
        .MAP_BASE(MAP_BASE), .MAP_STRIDE(MAP_STRIDE),
        .ZERO_TGT(ZERO_TGT), .NEG_TGT(NEG_TGT)
    ) u_rom (
        .addr_i (st_q.car),
        .word_o (rom_word)
    );

    useq_map #(
        .ADDR_W(ADDR_W), .OPC_W(OPC_W),
        .MAP_BASE(MAP_BASE), .MAP_STRIDE(MAP_STRIDE)
    ) u_map (
        .opcode_i (opcode_i),
        .addr_o   (map_addr)
    );

    useq_branch #(.ADDR_W(ADDR_W)) u_branch (
        .is_br_i    (cbr_is_br),
        .cond_i     (cbr_cond),
        .target_i   (cbr_target),
        .car_i      (st_q.car),
        .flag_z_i   (flag_z_i),
        .flag_n_i   (flag_n_i),
        .map_addr_i (map_addr),
        .next_o     (next_addr)
    );

    always_comb begin
        st_d = st_q;
        if (st_q.ph == PH_FETCH) begin
            st_d.cbr = rom_word;
            st_d.ph  = PH_EXEC;
        end else begin
            st_d.car = next_addr;
            st_d.ph  = PH_FETCH;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{car: '0, cbr: '0, ph: PH_FETCH};
        end else begin
            st_q <= st_d;
        end
    end

    assign exec_o  = (st_q.ph == PH_EXEC);
    assign uaddr_o = st_q.car;
    assign ctrl_o  = (exec_o && !cbr_is_br) ? st_q.cbr[CTRL_W-1:0] : '0;

endmodule

// File: rtl/useq_chk.sv
module useq_chk #(
    parameter int ADDR_W     = 6,
    parameter int CTRL_W     = 12,
    parameter int OPC_W      = 3,
    parameter int MAP_BASE   = 32,
    parameter int MAP_STRIDE = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [OPC_W-1:0]  opcode_i,
    input logic              flag_z_i,
    input logic              flag_n_i,
    input logic [CTRL_W-1:0] ctrl_o,
    input logic [ADDR_W-1:0] uaddr_o,
    input logic              exec_o,
    input logic              cbr_is_br,
    input logic [1:0]        cbr_cond,
    input logic [ADDR_W-1:0] cbr_target
);
    localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (uaddr_o == '0 && !exec_o && ctrl_o == '0)); // R1

    AST_PHASE_ALT: assert property (@(posedge clk) disable iff (!rst_n)
        exec_o |=> !exec_o); // R2

    AST_PHASE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_o |=> exec_o); // R2

    AST_FETCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_o |-> ctrl_o == '0); // R2

    AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_o |=> uaddr_o == $past(uaddr_o)); // R2

    AST_SEQ_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_o && !cbr_is_br) |=> uaddr_o == $past(uaddr_o) + ONE_A); // R3

    AST_BR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_o && cbr_is_br) |-> ctrl_o == '0); // R4

    AST_JMP: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_o && cbr_is_br && cbr_cond == 2'b00) |=> uaddr_o == $past(cbr_target)); // R5

    AST_JZ: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_o && cbr_is_br && cbr_cond == 2'b01) |=>
        uaddr_o == ($past(flag_z_i) ? $past(cbr_target) : $past(uaddr_o) + ONE_A)); // R6

    AST_JN: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_o && cbr_is_br && cbr_cond == 2'b10) |=>
        uaddr_o == ($past(flag_n_i) ? $past(cbr_target) : $past(uaddr_o) + ONE_A)); // R7

    AST_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_o && cbr_is_br && cbr_cond == 2'b11) |=>
        uaddr_o == ADDR_W'(MAP_BASE) + ADDR_W'($past(opcode_i)) * ADDR_W'(MAP_STRIDE)); // R8

endmodule

bind useq_core useq_chk #(
    .ADDR_W(ADDR_W), .CTRL_W(CTRL_W), .OPC_W(OPC_W),
    .MAP_BASE(MAP_BASE), .MAP_STRIDE(MAP_STRIDE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .opcode_i   (opcode_i),
    .flag_z_i   (flag_z_i),
    .flag_n_i   (flag_n_i),
    .ctrl_o     (ctrl_o),
    .uaddr_o    (uaddr_o),
    .exec_o     (exec_o),
    .cbr_is_br  (cbr_is_br),
    .cbr_cond   (cbr_cond),
    .cbr_target (cbr_target)
);

// File: tb/sim_useq_core.sv
`timescale 1ns/100ps
module sim_useq_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  opcode = 3'd0;
    logic        fz = 1'b0;
    logic        fn = 1'b0;
    logic [11:0] ctrl;
    logic [5:0]  uaddr;
    logic        exec;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    useq_core u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .opcode_i (opcode),
        .flag_z_i (fz),
        .flag_n_i (fn),
        .ctrl_o   (ctrl),
        .uaddr_o  (uaddr),
        .exec_o   (exec)
    );

    task automatic chk(input string rq, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
        end
    endtask

    // One microinstruction: fetch sample, then execute sample.
    task automatic micro(input int ua, input int cv,
                         input logic [2:0] of, input logic zf, input logic nf,
                         input logic [2:0] oe, input logic ze, input logic ne,
                         input string rq);
        opcode = of; fz = zf; fn = nf;
        chk("R2", "fetch exec_o", int'(exec), 0);
        chk("R2", "fetch ctrl_o", int'(ctrl), 0);
        chk(rq, "fetch uaddr_o", int'(uaddr), ua);
        @(negedge clk);
        opcode = oe; fz = ze; fn = ne;
        chk("R2", "exec exec_o", int'(exec), 1);
        chk(rq, "exec ctrl_o", int'(ctrl), cv);
        chk(rq, "exec uaddr_o", int'(uaddr), ua);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "reset uaddr_o", int'(uaddr), 0);
        chk("R1", "reset exec_o", int'(exec), 0);
        chk("R1", "reset ctrl_o", int'(ctrl), 0);
        rst_n = 1'b1;
        chk("R1", "first uaddr_o", int'(uaddr), 0);
    endtask

    // Full machine instruction: fetch routine, dispatch, opcode routine.
    task automatic t_instr(input logic [2:0] k, input logic z, input logic n);
        logic [2:0] nk;
        int base;
        bit taken;
        nk = ~k;
        base = 32 + 4 * int'(k);
        micro(0, 12'h001, nk, 1, 1, nk, 1, 1, "R3");
        micro(1, 12'h002, nk, 1, 1, nk, 1, 1, "R9");
        micro(2, 0, nk, 1, 1, k, ~z, ~n, "R11");
        micro(base, 12'h400 | (int'(k) << 4), nk, 1, 1, nk, 1, 1, "R8");
        taken = k[0] ? n : z;
        if (k[0]) micro(base + 1, 0, nk, ~z, ~n, nk, ~n, n, "R7");
        else      micro(base + 1, 0, nk, ~z, ~n, nk, z, ~z, "R6");
        if (taken) begin
            micro(k[0] ? 12 : 8, k[0] ? 12'h0C0 : 12'h0A0, nk, 1, 1, nk, 1, 1, "R10");
            micro(k[0] ? 13 : 9, 0, nk, 0, 0, nk, ~z, ~n, "R5");
        end else begin
            micro(base + 2, 12'h200 | (int'(k) << 4), nk, 1, 1, nk, 1, 1, "R9");
            micro(base + 3, 0, nk, 0, 0, nk, ~z, ~n, "R4");
        end
        chk("R5", "return uaddr_o", int'(uaddr), 0);
    endtask

    task automatic t_mid_reset();
        micro(0, 12'h001, 3'd5, 0, 0, 3'd5, 0, 0, "R3");
        // now in fetch of address 1; move to its execute cycle then reset
        @(negedge clk);
        chk("R2", "pre-reset exec_o", int'(exec), 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "mid reset uaddr_o", int'(uaddr), 0);
        chk("R1", "mid reset exec_o", int'(exec), 0);
        chk("R1", "mid reset ctrl_o", int'(ctrl), 0);
        rst_n = 1'b1;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        for (int k = 0; k < 8; k++) begin
            for (int f = 0; f < 4; f++) begin
                t_instr(3'(k), f[0], f[1]);
            end
        end
        t_mid_reset();
        t_instr(3'd6, 1'b1, 1'b0);
        t_instr(3'd3, 1'b0, 1'b1);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule